// File: doc/BRIEF.md
# Frame and Burst Timing Sequencer

This block is the timing core of a time-division duplex controller. A four-state machine (idle, armed, waiting, running) decides when frames are produced. One counter measures first a startup delay and then each frame. The frame counter it exports is the time base that per-channel on/off comparators elsewhere in the chip use, because every channel edge is placed relative to the start of a frame.

Software programs the startup delay, frame length and burst length while the block is disabled, then sets the enable input. The machine arms and waits for a combined sync pulse. It counts out the startup delay and then plays the requested number of frames, or plays frames without end when the burst length is zero. An optional sync-reset mode lets a later sync pulse pull the counter back to zero, so that frames stay aligned to an outside time reference.

Top module: `tdd_frame_seq`

## Requirements
- R1: After reset the state code is 0 (idle), the frame counter output is 0, and both the running flag and the frame-end strobe are low.
- R2: State codes are idle=0, armed=1, waiting=2 and running=3. In idle with enable high, the state is armed after the next clock edge.
- R3: In armed, the machine stays armed until it samples sync high. It is then in waiting after that edge, with its counter at zero.
- R4: Waiting lasts startup delay + 1 cycles, after which the state is running with the frame counter at 0. Outside running, the frame counter output reads 0.
- R5: In running, the frame counter steps by one each cycle from 0 to frame length − 1 and then wraps to 0. The frame-end strobe is high exactly in the cycle in which the counter shows frame length − 1. A frame length of 0 or 1 acts as 1.
- R6: With a non-zero burst length N, the state is armed in the cycle after the Nth frame-end strobe, and the running flag is low.
- R7: With burst length 0, frames repeat without end and one frame-end strobe is produced every frame length cycles.
- R8: When sync-reset is set, a sync pulse in running zeroes the frame counter on the next edge. The strobe is suppressed in that cycle, and the cut frame does not count toward the burst. When sync-reset is clear, sync pulses in running have no effect.
- R9: When sync-reset is set, a sync pulse in waiting restarts the startup delay from zero.
- R10: Clearing enable puts the machine in idle with the counter at zero after the next clock edge, from any state.
- R11: Startup delay, frame length and burst length are captured only while enable is low. Changes to them while enabled do not affect the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Run request; low forces idle and opens the configuration capture |
| sync_i | input | 1 | Combined sync pulse from all sync sources |
| sync_rst_en_i | input | 1 | Allow sync to zero the counter in waiting and running |
| startup_dly_i | input | CNT_W | Startup delay in cycles |
| frame_len_i | input | CNT_W | Frame length in cycles |
| burst_len_i | input | BURST_W | Frames per burst, 0 means endless |
| frame_cnt_o | output | CNT_W | Position inside the current frame, 0 outside running |
| state_o | output | 2 | State code for status readback |
| running_o | output | 1 | High while in running |
| frame_end_o | output | 1 | High in the last cycle of each frame |

## Verification
The assertions assume that configuration values reach the counter only through the capture stage, so the frame length and startup delay seen by the state machine never move while enable is high. They also assume that every input holds a known value from reset onward. The bench changes every input only at falling clock edges and keeps sync pulses one cycle wide. While running, it moves the configuration inputs to confirm that they have no effect. Every state check is made a full half cycle after the edge that produced it.

// File: rtl/tdd_seq_pkg.sv
package tdd_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_WAITING = 2'd2,
        ST_RUNNING = 2'd3
    } seq_state_e;
endpackage

// File: rtl/tdd_cfg_hold.sv
module tdd_cfg_hold #(
    parameter int CNT_W   = 16,
    parameter int BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic [CNT_W-1:0]   dly_i,
    input  logic [CNT_W-1:0]   len_i,
    input  logic [BURST_W-1:0] burst_i,
    output logic [CNT_W-1:0]   dly_o,
    output logic [CNT_W-1:0]   len_o,
    output logic [BURST_W-1:0] burst_o
);
    typedef struct packed {
        logic [CNT_W-1:0]   dly;
        logic [CNT_W-1:0]   len;
        logic [BURST_W-1:0] burst;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!enable_i) begin
            cfg_d.dly   = dly_i;
            cfg_d.len   = len_i;
            cfg_d.burst = burst_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign dly_o   = cfg_q.dly;
    assign len_o   = cfg_q.len;
    assign burst_o = cfg_q.burst;

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i |=> $stable(cfg_q));
endmodule

// File: rtl/tdd_seq_core.sv
module tdd_seq_core
    import tdd_seq_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic               sync_i,
    input  logic               sync_rst_en_i,
    input  logic [CNT_W-1:0]   dly_i,
    input  logic [CNT_W-1:0]   len_i,
    input  logic [BURST_W-1:0] burst_i,
    output logic [CNT_W-1:0]   cnt_o,
    output seq_state_e         state_o,
    output logic               frame_end_o
);
    localparam logic [CNT_W-1:0]   CNT_ONE   = CNT_W'(1);
    localparam logic [BURST_W-1:0] BURST_ONE = BURST_W'(1);

    typedef struct packed {
        seq_state_e         state;
        logic [CNT_W-1:0]   cnt;
        logic [BURST_W-1:0] done;
    } core_t;

    core_t core_d, core_q;
    logic  frame_end_d;
    logic  sync_clr;
    logic  frame_last;

    always_comb begin
        core_d      = core_q;
        frame_end_d = 1'b0;
        sync_clr    = sync_i && sync_rst_en_i;
        frame_last  = (len_i <= CNT_ONE) || (core_q.cnt == len_i - CNT_ONE);
        if (!enable_i) begin
            core_d = '{state: ST_IDLE, cnt: '0, done: '0};
        end else begin
            unique case (core_q.state)
                ST_IDLE: begin
                    core_d = '{state: ST_ARMED, cnt: '0, done: '0};
                end
                ST_ARMED: begin
                    if (sync_i) core_d = '{state: ST_WAITING, cnt: '0, done: '0};
                end
                ST_WAITING: begin
                    if (sync_clr) begin
                        core_d.cnt = '0;
                    end else if (core_q.cnt == dly_i) begin
                        core_d.state = ST_RUNNING;
                        core_d.cnt   = '0;
                    end else begin
                        core_d.cnt = core_q.cnt + CNT_ONE;
                    end
                end
                ST_RUNNING: begin
                    if (sync_clr) begin
                        core_d.cnt = '0;
                    end else if (frame_last) begin
                        frame_end_d = 1'b1;
                        core_d.cnt  = '0;
                        core_d.done = core_q.done + BURST_ONE;
                        if (burst_i != '0 && (core_q.done + BURST_ONE) == burst_i)
                            core_d.state = ST_ARMED;
                    end else begin
                        core_d.cnt = core_q.cnt + CNT_ONE;
                    end
                end
                default: core_d = '{state: ST_IDLE, cnt: '0, done: '0};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '{state: ST_IDLE, cnt: '0, done: '0};
        else        core_q <= core_d;
    end

    assign state_o     = core_q.state;
    assign cnt_o       = (core_q.state == ST_RUNNING) ? core_q.cnt : '0;
    assign frame_end_o = frame_end_d;

    // R10
    disable_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (state_o == ST_IDLE && cnt_o == '0));

    // R2
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE) |=> (state_o == ST_IDLE || state_o == ST_ARMED));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RUNNING && len_i > CNT_ONE) |-> (cnt_o < len_i));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> (cnt_o == '0));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && state_o == ST_RUNNING && !frame_end_o && !(sync_i && sync_rst_en_i))
        |=> (cnt_o == $past(cnt_o) + CNT_ONE));

    // R3
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && state_o == ST_ARMED && !sync_i) |=> (state_o == ST_ARMED));
endmodule

// File: rtl/tdd_frame_seq.sv
module tdd_frame_seq
    import tdd_seq_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic               sync_i,
    input  logic               sync_rst_en_i,
    input  logic [CNT_W-1:0]   startup_dly_i,
    input  logic [CNT_W-1:0]   frame_len_i,
    input  logic [BURST_W-1:0] burst_len_i,
    output logic [CNT_W-1:0]   frame_cnt_o,
    output logic [1:0]         state_o,
    output logic               running_o,
    output logic               frame_end_o
);
    logic [CNT_W-1:0]   dly_w, len_w;
    logic [BURST_W-1:0] burst_w;
    seq_state_e         state_w;

    tdd_cfg_hold #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .dly_i    (startup_dly_i),
        .len_i    (frame_len_i),
        .burst_i  (burst_len_i),
        .dly_o    (dly_w),
        .len_o    (len_w),
        .burst_o  (burst_w)
    );

    tdd_seq_core #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable_i),
        .sync_i        (sync_i),
        .sync_rst_en_i (sync_rst_en_i),
        .dly_i         (dly_w),
        .len_i         (len_w),
        .burst_i       (burst_w),
        .cnt_o         (frame_cnt_o),
        .state_o       (state_w),
        .frame_end_o   (frame_end_o)
    );

    assign state_o   = state_w;
    assign running_o = (state_w == ST_RUNNING);

    // R6
    running_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |-> (state_o == 2'd3));
endmodule

// File: tb/sim_tdd_frame_seq.sv
module sim_tdd_frame_seq;
    localparam int CW = 16;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable_i = 1'b0;
    logic          sync_i = 1'b0;
    logic          sync_rst_en_i = 1'b0;
    logic [CW-1:0] startup_dly_i = '0;
    logic [CW-1:0] frame_len_i = '0;
    logic [BW-1:0] burst_len_i = '0;
    logic [CW-1:0] frame_cnt_o;
    logic [1:0]    state_o;
    logic          running_o;
    logic          frame_end_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tdd_frame_seq #(.CNT_W(CW), .BURST_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .sync_i(sync_i),
        .sync_rst_en_i(sync_rst_en_i), .startup_dly_i(startup_dly_i),
        .frame_len_i(frame_len_i), .burst_len_i(burst_len_i),
        .frame_cnt_o(frame_cnt_o), .state_o(state_o),
        .running_o(running_o), .frame_end_o(frame_end_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic configure(input int dly, input int len, input int bl, input bit srst);
        enable_i = 1'b0;
        startup_dly_i = CW'(dly);
        frame_len_i = CW'(len);
        burst_len_i = BW'(bl);
        sync_rst_en_i = srst;
        step(2);
    endtask

    task automatic pulse_sync();
        sync_i = 1'b1;
        step(1);
        sync_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 state", int'(state_o), 0);
        chk("R1 cnt", int'(frame_cnt_o), 0);
        chk("R1 running", int'(running_o), 0);
        chk("R1 frame_end", int'(frame_end_o), 0);
    endtask

    task automatic t_burst();
        configure(3, 5, 2, 1'b0);
        enable_i = 1'b1;
        step(1);
        chk("R2 armed", int'(state_o), 1);
        step(3);
        chk("R3 no sync stays armed", int'(state_o), 1);
        pulse_sync();
        chk("R3 waiting", int'(state_o), 2);
        step(3);
        chk("R4 still waiting", int'(state_o), 2);
        chk("R4 cnt zero outside running", int'(frame_cnt_o), 0);
        // R11: move config while enabled
        frame_len_i = CW'(2);
        burst_len_i = BW'(1);
        startup_dly_i = CW'(9);
        step(1);
        chk("R4 running", int'(state_o), 3);
        chk("R4 cnt start", int'(frame_cnt_o), 0);
        step(4);
        chk("R5 cnt last", int'(frame_cnt_o), 4);
        chk("R5 strobe", int'(frame_end_o), 1);
        step(1);
        chk("R5 wrap", int'(frame_cnt_o), 0);
        chk("R5 strobe low", int'(frame_end_o), 0);
        chk("R11 burst ignored", int'(state_o), 3);
        step(4);
        chk("R11 len ignored", int'(frame_end_o), 1);
        step(1);
        chk("R6 armed after burst", int'(state_o), 1);
        chk("R6 running low", int'(running_o), 0);
        enable_i = 1'b0;
        step(1);
        chk("R10 idle", int'(state_o), 0);
    endtask

    task automatic t_forever();
        int ends;
        configure(0, 3, 0, 1'b0);
        enable_i = 1'b1;
        step(1);
        pulse_sync();
        chk("R4 zero delay waiting", int'(state_o), 2);
        step(1);
        chk("R4 zero delay running", int'(state_o), 3);
        step(1);
        pulse_sync();
        chk("R8 sync ignored without option", int'(frame_cnt_o), 2);
        ends = 0;
        for (int i = 0; i < 60; i++) begin
            step(1);
            if (frame_end_o) ends++;
        end
        chk("R7 endless strobes", ends, 20);
        chk("R7 still running", int'(running_o), 1);
        enable_i = 1'b0;
        step(1);
        chk("R10 idle from running", int'(state_o), 0);
        chk("R10 cnt zero", int'(frame_cnt_o), 0);
    endtask

    task automatic t_syncrst();
        configure(4, 6, 1, 1'b1);
        enable_i = 1'b1;
        step(1);
        pulse_sync();
        step(2);
        pulse_sync();
        step(4);
        chk("R9 delay restarted", int'(state_o), 2);
        step(1);
        chk("R9 running after restart", int'(state_o), 3);
        step(5);
        chk("R8 at last", int'(frame_cnt_o), 5);
        sync_i = 1'b1;
        #1;
        chk("R8 strobe suppressed", int'(frame_end_o), 0);
        step(1);
        sync_i = 1'b0;
        chk("R8 cnt zeroed", int'(frame_cnt_o), 0);
        chk("R8 frame not counted", int'(state_o), 3);
        step(5);
        chk("R8 full frame strobe", int'(frame_end_o), 1);
        step(1);
        chk("R6 armed after one frame", int'(state_o), 1);
        enable_i = 1'b0;
        step(1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_burst();
        t_forever();
        t_syncrst();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule